// File: doc/BRIEF.md
# Best-Fit Clock Divider Search Engine

This block picks the clock source, fractional predivider and integer divider that bring a derived clock as close as possible to a requested rate. It is given the requested rate and the rates of three candidate sources: an external reference, a first PLL and a second PLL. It then runs an exhaustive search over all nine combinations of source and predivider. The result is a pair of source-select bits, a predivider code, a 7-bit divider, the rate that setting achieves, and a flag that says whether any legal setting exists. Writing the result into a clock-control register is left to the surrounding logic.

The engine is sequential and has one shift-subtract divider. A one-cycle `start` pulse, taken while `busy` is low, captures all inputs. `busy` stays high until the cycle in which `done` pulses. The result ports are valid in that cycle and keep their values until the next accepted start. There is no data stream here, so no valid/ready pair is used. `start` and `done` are plain control strobes and carry no back-pressure: a start that arrives while the engine is busy is dropped.

Predividers of 2, 2.5 and 3 are handled in integer arithmetic. Every source rate is doubled, and the predivider is expressed in half units as p = 4, 5 or 6.

Top module: `clkdiv_search`

## Requirements
- R1: The search uses an effective rate equal to the requested rate, clamped to the largest of floor(ext/4), floor(pll_a/4) and floor(pll_b/4).
- R2: Sources are visited in the order external, first PLL, second PLL, and p runs 4, 5, 6 for each source. When two candidates have equal error, the earlier one in this order is kept.
- R3: For each candidate the divider is floor(2·source / (rate·p)). A candidate is skipped when its divider is below 2 or above 127. When `found` is high, `div_val` holds the chosen divider.
- R4: A candidate's achieved rate is floor(2·source / (p·divider)). A candidate becomes the best if no candidate has been kept yet, or if its absolute error against the effective rate is strictly smaller. `achieved_rate` reports the rate of the best candidate.
- R5: Result encoding: `pre_code` = p−3, giving 1, 2 or 3 for a predivider of 2, 2.5 or 3. `pll_sel` is 1 when either PLL is chosen. `pll_b_sel` is 1 only when the second PLL is chosen.
- R6: When no candidate passes, `found` is 0 at `done`, and `pll_sel`, `pll_b_sel`, `pre_code`, `div_val` and `achieved_rate` are all 0.
- R7: When the effective rate is zero (a zero request, or every source below 4), the job is rejected. `done` is then high in the cycle after the first clock edge that follows the accepting edge (latency 1), and the outputs are as in R6.
- R8: Every other job has fixed latency. `done` is high for one cycle, L = 1 + 9·(2·(RATE_W+3)+5) clock edges after the accepting edge (676 for RATE_W = 32), whatever the inputs.
- R9: `start` is accepted only while `busy` is low. `busy` is high from the edge after acceptance through the `done` cycle. A start pulse or input change while busy has no effect on the running job.
- R10: The result outputs do not change from the `done` cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; captures all rate inputs when busy is low |
| req_rate | input | RATE_W | Requested output rate |
| ext_rate | input | RATE_W | External reference rate |
| pll_a_rate | input | RATE_W | First PLL rate |
| pll_b_rate | input | RATE_W | Second PLL rate |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A legal setting was found |
| pll_sel | output | 1 | Chosen source is a PLL |
| pll_b_sel | output | 1 | Chosen source is the second PLL |
| pre_code | output | 2 | Predivider code (p−3) |
| div_val | output | 7 | Chosen integer divider |
| achieved_rate | output | RATE_W | Rate produced by the chosen setting |

## Verification
The hardest outcomes to reach from the ports are the tie between sources and the case where every candidate is rejected. Reaching them means choosing rates so that equal errors occur, or so that every divider falls outside 2 to 127. The stimulus gives all three sources the same rate to force exact ties. It pairs a request of 1 with large sources so that every divider overflows, and it uses sources below 4 to drive the clamp to zero. A second start pulse with altered inputs is also sent in the middle of a search, to show that the captured job runs on unchanged. Random jobs are run as well, and a behavioural model checks busy, done and all result fields on every clock.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NUM_SRC  = 3;
  localparam int P_MIN    = 4;
  localparam int P_MAX    = 6;
  localparam int P_W      = 3;
  localparam int CODE_W   = 2;
  localparam int DIV_W    = 7;
  localparam int DIV_LO   = 2;
  localparam int DIV_HI   = 127;
  localparam int SRC_IDXW = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_LAUNCH_A,
    ST_WAIT_A,
    ST_LAUNCH_B,
    ST_WAIT_B,
    ST_EVAL,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/clkdiv_serial_div.sv
module clkdiv_serial_div #(
  parameter int WIDTH = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] num,
  input  logic [WIDTH-1:0] den,
  output logic             busy,
  output logic [WIDTH-1:0] quo
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] rem;
  logic [WIDTH-1:0] den_q;
  logic [WIDTH:0]   trial;
  logic [WIDTH:0]   diff;
  logic             bit_n;
  logic [WIDTH-1:0] rem_n;

  always_comb begin
    trial = {rem, quo[WIDTH-1]};
    diff  = trial - {1'b0, den_q};
    if (trial >= {1'b0, den_q}) begin
      bit_n = 1'b1;
      rem_n = diff[WIDTH-1:0];
    end else begin
      bit_n = 1'b0;
      rem_n = trial[WIDTH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rem   <= '0;
      quo   <= '0;
      den_q <= '0;
    end else if (load) begin
      cnt   <= CW'(WIDTH);
      rem   <= '0;
      quo   <= num;
      den_q <= den;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      rem <= rem_n;
      quo <= {quo[WIDTH-2:0], bit_n};
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/clkdiv_best_keep.sv
module clkdiv_best_keep
  import clkdiv_pkg::*;
#(
  parameter int RATE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                offer,
  input  logic [RATE_W-1:0]   cand_err,
  input  logic [RATE_W-1:0]   cand_rate,
  input  logic [SRC_IDXW-1:0] cand_src,
  input  logic [CODE_W-1:0]   cand_code,
  input  logic [DIV_W-1:0]    cand_div,
  output logic                found,
  output logic                pll_sel,
  output logic                pll_b_sel,
  output logic [CODE_W-1:0]   pre_code,
  output logic [DIV_W-1:0]    div_val,
  output logic [RATE_W-1:0]   achieved_rate
);
  logic [RATE_W-1:0] err_q;
  logic              take;

  // strict improvement only: an equal error keeps the earlier candidate
  assign take = offer && (!found || (cand_err < err_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found         <= 1'b0;
      pll_sel       <= 1'b0;
      pll_b_sel     <= 1'b0;
      pre_code      <= '0;
      div_val       <= '0;
      achieved_rate <= '0;
      err_q         <= '0;
    end else if (clear) begin
      found         <= 1'b0;
      pll_sel       <= 1'b0;
      pll_b_sel     <= 1'b0;
      pre_code      <= '0;
      div_val       <= '0;
      achieved_rate <= '0;
      err_q         <= '0;
    end else if (take) begin
      found         <= 1'b1;
      pll_sel       <= (cand_src != '0);
      pll_b_sel     <= (cand_src == SRC_IDXW'(NUM_SRC - 1));
      pre_code      <= cand_code;
      div_val       <= cand_div;
      achieved_rate <= cand_rate;
      err_q         <= cand_err;
    end
  end
endmodule

// File: rtl/clkdiv_search_ctrl.sv
module clkdiv_search_ctrl
  import clkdiv_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int DW     = RATE_W + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [RATE_W-1:0]   req_rate,
  input  logic [RATE_W-1:0]   ext_rate,
  input  logic [RATE_W-1:0]   pll_a_rate,
  input  logic [RATE_W-1:0]   pll_b_rate,
  output logic                busy,
  output logic                done,
  output logic                div_load,
  output logic [DW-1:0]       div_num,
  output logic [DW-1:0]       div_den,
  input  logic                div_busy,
  input  logic [DW-1:0]       div_quo,
  output logic                keep_clear,
  output logic                keep_offer,
  output logic [RATE_W-1:0]   cand_err,
  output logic [RATE_W-1:0]   cand_rate,
  output logic [SRC_IDXW-1:0] cand_src,
  output logic [CODE_W-1:0]   cand_code,
  output logic [DIV_W-1:0]    cand_div
);
  seq_state_t        state;
  logic [RATE_W-1:0] src_q [NUM_SRC];
  logic [RATE_W-1:0] req_q;
  logic [RATE_W-1:0] rate_q;
  logic [SRC_IDXW-1:0] si;
  logic [P_W-1:0]    pi;
  logic [DIV_W-1:0]  q_lo;
  logic              in_range_q;

  logic [RATE_W-1:0] quarter [NUM_SRC];
  logic [RATE_W-1:0] quarter_max;
  logic [RATE_W-1:0] eff_rate;
  logic [RATE_W-1:0] cur_src;
  logic              accept;
  logic              last_p;
  logic              last_src;

  assign accept = (state == ST_IDLE) && start;

  // one quarter-rate per source, then the running maximum
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_quarter
    assign quarter[g] = src_q[g] >> 2;
  end

  always_comb begin
    quarter_max = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (quarter[k] > quarter_max) quarter_max = quarter[k];
    end
    eff_rate = (req_q < quarter_max) ? req_q : quarter_max;
  end

  assign cur_src  = src_q[si];
  assign last_p   = (pi == P_W'(P_MAX));
  assign last_src = (si == SRC_IDXW'(NUM_SRC - 1));

  // operand selection for the shared divider
  always_comb begin
    div_num = DW'({cur_src, 1'b0});
    if (state == ST_LAUNCH_B) div_den = DW'(pi) * DW'(q_lo);
    else                      div_den = DW'(rate_q) * DW'(pi);
  end
  assign div_load = (state == ST_LAUNCH_A) || (state == ST_LAUNCH_B);

  // candidate evaluation after the second division
  always_comb begin
    cand_rate = div_quo[RATE_W-1:0];
    if (cand_rate >= rate_q) cand_err = cand_rate - rate_q;
    else                     cand_err = rate_q - cand_rate;
    cand_src  = si;
    cand_code = CODE_W'(pi - P_W'(P_MIN - 1));
    cand_div  = q_lo;
  end
  assign keep_clear = accept;
  assign keep_offer = (state == ST_EVAL) && in_range_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      req_q      <= '0;
      rate_q     <= '0;
      si         <= '0;
      pi         <= P_W'(P_MIN);
      q_lo       <= '0;
      in_range_q <= 1'b0;
      for (int k = 0; k < NUM_SRC; k++) src_q[k] <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            req_q    <= req_rate;
            src_q[0] <= ext_rate;
            src_q[1] <= pll_a_rate;
            src_q[2] <= pll_b_rate;
            state    <= ST_PREP;
          end
        end
        ST_PREP: begin
          rate_q <= eff_rate;
          si     <= '0;
          pi     <= P_W'(P_MIN);
          state  <= (eff_rate == '0) ? ST_DONE : ST_LAUNCH_A;
        end
        ST_LAUNCH_A: state <= ST_WAIT_A;
        ST_WAIT_A: begin
          if (!div_busy) begin
            q_lo       <= div_quo[DIV_W-1:0];
            in_range_q <= (div_quo >= DW'(DIV_LO)) && (div_quo <= DW'(DIV_HI));
            state      <= ST_LAUNCH_B;
          end
        end
        ST_LAUNCH_B: state <= ST_WAIT_B;
        ST_WAIT_B: begin
          if (!div_busy) state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (last_p) begin
            pi <= P_W'(P_MIN);
            if (last_src) begin
              state <= ST_DONE;
            end else begin
              si    <= si + 1'b1;
              state <= ST_LAUNCH_A;
            end
          end else begin
            pi    <= pi + 1'b1;
            state <= ST_LAUNCH_A;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
  import clkdiv_pkg::*;
#(
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] req_rate,
  input  logic [RATE_W-1:0] ext_rate,
  input  logic [RATE_W-1:0] pll_a_rate,
  input  logic [RATE_W-1:0] pll_b_rate,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic              pll_sel,
  output logic              pll_b_sel,
  output logic [1:0]        pre_code,
  output logic [6:0]        div_val,
  output logic [RATE_W-1:0] achieved_rate
);
  localparam int DW = RATE_W + 3;

  logic                div_load;
  logic [DW-1:0]       div_num;
  logic [DW-1:0]       div_den;
  logic                div_busy;
  logic [DW-1:0]       div_quo;
  logic                keep_clear;
  logic                keep_offer;
  logic [RATE_W-1:0]   cand_err;
  logic [RATE_W-1:0]   cand_rate;
  logic [SRC_IDXW-1:0] cand_src;
  logic [CODE_W-1:0]   cand_code;
  logic [DIV_W-1:0]    cand_div;

  clkdiv_search_ctrl #(.RATE_W(RATE_W), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .req_rate   (req_rate),
    .ext_rate   (ext_rate),
    .pll_a_rate (pll_a_rate),
    .pll_b_rate (pll_b_rate),
    .busy       (busy),
    .done       (done),
    .div_load   (div_load),
    .div_num    (div_num),
    .div_den    (div_den),
    .div_busy   (div_busy),
    .div_quo    (div_quo),
    .keep_clear (keep_clear),
    .keep_offer (keep_offer),
    .cand_err   (cand_err),
    .cand_rate  (cand_rate),
    .cand_src   (cand_src),
    .cand_code  (cand_code),
    .cand_div   (cand_div)
  );

  clkdiv_serial_div #(.WIDTH(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (div_load),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .quo   (div_quo)
  );

  clkdiv_best_keep #(.RATE_W(RATE_W)) u_keep (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (keep_clear),
    .offer         (keep_offer),
    .cand_err      (cand_err),
    .cand_rate     (cand_rate),
    .cand_src      (cand_src),
    .cand_code     (cand_code),
    .cand_div      (cand_div),
    .found         (found),
    .pll_sel       (pll_sel),
    .pll_b_sel     (pll_b_sel),
    .pre_code      (pre_code),
    .div_val       (div_val),
    .achieved_rate (achieved_rate)
  );
endmodule

// File: rtl/clkdiv_search_chk.sv
module clkdiv_search_chk #(
  parameter int RATE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              found,
  input logic              pll_sel,
  input logic              pll_b_sel,
  input logic [1:0]        pre_code,
  input logic [6:0]        div_val,
  input logic [RATE_W-1:0] achieved_rate
);
  localparam int LAT_FULL = 1 + 9 * (2 * (RATE_W + 3) + 5);

  logic [15:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       lat_cnt <= '0;
    else if (start && !busy)          lat_cnt <= '0;
    else if (busy && lat_cnt != '1)   lat_cnt <= lat_cnt + 1'b1;
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == 16'(LAT_FULL) || lat_cnt == 16'd1));

  a_r9_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({found, pll_sel, pll_b_sel, pre_code, div_val, achieved_rate}));

  a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (div_val >= 7'd2 && div_val <= 7'd127));

  a_r5_encoding: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (pre_code != 2'd0 && (!pll_b_sel || pll_sel)));

  a_r6_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (div_val == '0 && achieved_rate == '0 && pre_code == '0
                          && !pll_sel && !pll_b_sel));
endmodule

bind clkdiv_search clkdiv_search_chk #(.RATE_W(RATE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .done          (done),
  .found         (found),
  .pll_sel       (pll_sel),
  .pll_b_sel     (pll_b_sel),
  .pre_code      (pre_code),
  .div_val       (div_val),
  .achieved_rate (achieved_rate)
);

// File: tb/clkdiv_search_test.sv
`timescale 1ns/1ps
module clkdiv_search_test;
  localparam int W        = 32;
  localparam int LAT_FULL = 1 + 9 * (2 * (W + 3) + 5);
  localparam int LAT_REJ  = 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] req_rate = '0, ext_rate = '0, pll_a_rate = '0, pll_b_rate = '0;
  logic         busy, done, found, pll_sel, pll_b_sel;
  logic [1:0]   pre_code;
  logic [6:0]   div_val;
  logic [W-1:0] achieved_rate;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  clkdiv_search #(.RATE_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req_rate),
    .ext_rate(ext_rate), .pll_a_rate(pll_a_rate), .pll_b_rate(pll_b_rate),
    .busy(busy), .done(done), .found(found), .pll_sel(pll_sel),
    .pll_b_sel(pll_b_sel), .pre_code(pre_code), .div_val(div_val),
    .achieved_rate(achieved_rate)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference of the whole search
  task automatic ref_search(input longint rq, input longint e, input longint a, input longint b,
                            output bit f, output bit ps, output bit pbs, output int code,
                            output int dv, output longint ar, output bit rej);
    longint src [3];
    longint mx, r, q, act, er, best;
    src[0] = e; src[1] = a; src[2] = b;
    mx = 0;
    foreach (src[k]) if (src[k] / 4 > mx) mx = src[k] / 4;
    r = (rq < mx) ? rq : mx;
    f = 0; ps = 0; pbs = 0; code = 0; dv = 0; ar = 0; best = 0;
    rej = (r == 0);
    if (rej) return;
    for (int s = 0; s < 3; s++) begin
      for (int p = 4; p <= 6; p++) begin
        q = (2 * src[s]) / (r * p);
        if (q < 2 || q > 127) continue;
        act = (2 * src[s]) / (p * q);
        er  = (act > r) ? act - r : r - act;
        if (!f || er < best) begin
          f = 1; best = er; ar = act; dv = int'(q); code = p - 3;
          ps = (s != 0); pbs = (s == 2);
        end
      end
    end
  endtask

  // cycle model: busy/done timing and held results
  bit     m_busy = 0;
  int     m_rem = 0;
  string  m_tag = "R8";
  bit     m_f, m_ps, m_pbs;
  int     m_code, m_dv;
  longint m_ar;

  always @(posedge clk) begin
    bit f, ps, pbs, rej; int code, dv; longint ar;
    if (!rst_n) begin
      m_busy = 0; m_rem = 0;
      m_f = 0; m_ps = 0; m_pbs = 0; m_code = 0; m_dv = 0; m_ar = 0;
    end else if (m_busy) begin
      if (m_rem == 0) m_busy = 0;
      else m_rem--;
    end else if (start) begin
      ref_search(req_rate, ext_rate, pll_a_rate, pll_b_rate, f, ps, pbs, code, dv, ar, rej);
      m_f = f; m_ps = ps; m_pbs = pbs; m_code = code; m_dv = dv; m_ar = ar;
      m_busy = 1;
      m_rem  = rej ? LAT_REJ : LAT_FULL;
      m_tag  = rej ? "R7" : "R8";
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_done;
      exp_done = m_busy && (m_rem == 0);
      chk("R9", "busy", busy, m_busy);
      chk(m_tag, "done", done, exp_done);
      if (!m_busy || exp_done) begin
        chk("R6", "found", found, m_f);
        chk("R3", "div_val", div_val, m_dv);
        chk("R5", "pre_code", pre_code, m_code);
        chk("R5", "pll_sel", pll_sel, m_ps);
        chk("R5", "pll_b_sel", pll_b_sel, m_pbs);
        chk("R4", "achieved_rate", achieved_rate, m_ar);
      end
    end
  end

  task automatic run_job(input string tag, input longint rq, input longint e, input longint a,
                         input longint b, input int exp_lat);
    int k;
    @(negedge clk);
    req_rate = W'(rq); ext_rate = W'(e); pll_a_rate = W'(a); pll_b_rate = W'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!done && k < LAT_FULL + 20);
    chk(tag, "latency", k, exp_lat);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [6:0] held_div;
    logic [W-1:0] held_rate;
    repeat (3) @(negedge clk);
    // reset state
    chk("R9", "busy at reset", busy, 0);
    chk("R6", "found at reset", found, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // typical job
    run_job("R8", 25000000, 14745600, 400000000, 384000000, LAT_FULL);
    chk("R4", "typical found", found, 1);

    // request above the clamp: effective rate is 400e6/4 on the first PLL, divider 2
    run_job("R8", 1000000000, 14745600, 400000000, 384000000, LAT_FULL);
    chk("R1", "clamped achieved", achieved_rate, 100000000);
    chk("R5", "clamped pll_sel", pll_sel, 1);
    chk("R5", "clamped pll_b_sel", pll_b_sel, 0);
    chk("R5", "clamped pre_code", pre_code, 1);
    chk("R3", "clamped div", div_val, 2);

    // hold after done
    held_div = div_val; held_rate = achieved_rate;
    repeat (6) @(negedge clk);
    chk("R10", "held div", div_val, held_div);
    chk("R10", "held rate", achieved_rate, held_rate);

    // ties: identical sources keep the external reference
    run_job("R8", 7000000, 50000000, 50000000, 50000000, LAT_FULL);
    chk("R2", "tie found", found, 1);
    chk("R2", "tie pll_sel", pll_sel, 0);
    chk("R2", "tie pll_b_sel", pll_b_sel, 0);

    // no candidate passes
    run_job("R8", 1, 100000, 100000, 100000, LAT_FULL);
    chk("R6", "none found", found, 0);
    chk("R6", "none div", div_val, 0);

    // zero request and zero clamp are rejected at once
    run_job("R7", 0, 14745600, 400000000, 384000000, LAT_REJ);
    chk("R7", "zero req found", found, 0);
    run_job("R7", 5, 3, 3, 3, LAT_REJ);
    chk("R7", "small src found", found, 0);

    // start and input changes during a job are ignored
    @(negedge clk);
    req_rate = W'(33000000); ext_rate = W'(14745600);
    pll_a_rate = W'(332000000); pll_b_rate = W'(192000000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    req_rate = W'(1); ext_rate = W'(9); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R9", "ignored start found", found, 1);
    repeat (3) @(negedge clk);

    // pseudo-random jobs
    for (int n = 0; n < 8; n++) begin
      longint e, a, b, r;
      bit f, ps, pbs, rej; int code, dv; longint ar;
      e = $urandom_range(2000000, 40000000);
      a = $urandom_range(100000000, 1000000000);
      b = $urandom_range(0, 1000000000);
      r = $urandom_range(100000, 300000000);
      ref_search(r, e, a, b, f, ps, pbs, code, dv, ar, rej);
      run_job(rej ? "R7" : "R8", r, e, a, b, rej ? LAT_REJ : LAT_FULL);
      chk("R4", "random rate", achieved_rate, ar);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule